// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Cell Array

This block places a boundary-scan cell between the core's port logic and the pad of each bidirectional digital pin. There are `PINS` pins. Each cell holds two serial stages. The control stage observes the core's output enable. The data stage observes the level at the pad input. Every cell also has two update latches behind its stages. The cells are chained into one serial register between `scan_in` and `scan_out`. A test access controller drives that register with capture, shift and update strobes, all qualified on the test clock.

Two decoded instruction flags pick the cell's role. With `mode_extest` set, the update latches take the pad: the control latch drives the pad enable and the data latch drives the pad value. With `mode_sample` set, the chain can take a snapshot of the pins and be preloaded, and the core keeps control of the pads. Either flag turns the pin pull-up off. The pad input always goes back to the core unchanged.

Top module: `bsc_pin_array`

## Requirements
- R1: While `rst` is high on a clock edge, all scan stages and all update latches clear to 0. After reset, `scan_out` reads 0.
- R2: A clock edge with `capture_en` high loads the control stage of pin p with `core_oe[p]` and the data stage of pin p with `pad_di[p]`.
- R3: A clock edge with `shift_en` high and `capture_en` low moves the chain by one stage. The chain runs from `scan_in` through pin 0 control, pin 0 data, pin 1 control, and so on up to pin PINS-1 data. `scan_out` is the data stage of pin PINS-1, so a bit leaves the chain 2*PINS edges after it enters.
- R4: When `capture_en` and `shift_en` are both high, capture wins and no shift takes place.
- R5: The update latches of pin p load the control and data stage values that stood before the edge, but only on an edge with `update_en` high. On every other edge they hold their value.
- R6: With `mode_extest` high, `pad_oe[p]` equals the control update latch of pin p and `pad_do[p]` equals its data update latch. The pad therefore stays steady while the chain shifts.
- R7: With `mode_extest` low, `pad_oe` equals `core_oe` and `pad_do` equals `core_do`. This holds for any value of `mode_sample` and whatever the update latches contain.
- R8: `core_di` always equals `pad_di` in the same cycle, in every mode.
- R9: `pullup_off` is high exactly when `mode_extest` or `mode_sample` is high.
- R10: On an edge with both `capture_en` and `shift_en` low, all scan stages keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial data into pin 0 control stage |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| mode_extest | input | 1 | External-test instruction active |
| mode_sample | input | 1 | Sample/preload instruction active |
| core_oe | input | PINS | Output enable from core port logic |
| core_do | input | PINS | Output data from core port logic |
| pad_di | input | PINS | Level seen at each pad input |
| scan_out | output | 1 | Serial data from pin PINS-1 data stage |
| pad_oe | output | PINS | Pad drive enable |
| pad_do | output | PINS | Pad drive value |
| core_di | output | PINS | Pad level returned to the core |
| pullup_off | output | 1 | Forces pin pull-ups off |

## Verification
Two checks are hard to reach from the ports. The first is that the pad stays frozen under external test while new data shifts through the chain. The second is that latches loaded while external test is off have no effect until the mode is switched. To get there, the stimulus preloads distinct patterns under sample/preload, confirms that the core still owns the pads, and then switches to external test. It then runs long shift bursts with pad-visible patterns differing from the shifted data. A reference model steps every cycle through random mixes of strobes and modes, including capture and shift together, and compares all outputs at each clock.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [1:0] {
        BSC_HOLD    = 2'd0,
        BSC_CAPTURE = 2'd1,
        BSC_SHIFT   = 2'd2
    } bsc_act_e;

    typedef struct packed {
        logic ctrl;
        logic data;
    } bsc_pair_t;

    typedef struct packed {
        logic extest;
        logic sample;
    } bsc_mode_t;

    // Capture has priority over shift.
    function automatic bsc_act_e bsc_decode(logic cap, logic shf);
        if (cap)      return BSC_CAPTURE;
        else if (shf) return BSC_SHIFT;
        else          return BSC_HOLD;
    endfunction

    // Next value of a cell's two stages; the control stage takes serial
    // input first, the data stage takes the old control stage.
    function automatic bsc_pair_t bsc_next(bsc_act_e act, bsc_pair_t cur,
                                           logic si, bsc_pair_t obs);
        bsc_pair_t n;
        case (act)
            BSC_CAPTURE: n = obs;
            BSC_SHIFT: begin
                n.ctrl = si;
                n.data = cur.ctrl;
            end
            default:     n = cur;
        endcase
        return n;
    endfunction

    function automatic logic bsc_pull_off(bsc_mode_t m);
        return m.extest | m.sample;
    endfunction

endpackage

// File: rtl/bsc_scan_stages.sv
module bsc_scan_stages
    import bsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bsc_act_e  act,
    input  logic      si,
    input  bsc_pair_t observe,
    output bsc_pair_t stage_q
);

    bsc_pair_t stage_n;

    always_comb stage_n = bsc_next(act, stage_q, si, observe);

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_n;
    end

    assert_capture_load_R2: assert property (@(posedge clk) disable iff (rst)
        act == BSC_CAPTURE |=> stage_q == $past(observe));

    assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
        act == BSC_SHIFT |=> stage_q.data == $past(stage_q.ctrl) && stage_q.ctrl == $past(si));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        act == BSC_HOLD |=> $stable(stage_q));

endmodule

// File: rtl/bsc_update_hold.sv
module bsc_update_hold
    import bsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      update_en,
    input  bsc_pair_t stage,
    output bsc_pair_t latch_q
);

    always_ff @(posedge clk) begin
        if (rst)            latch_q <= '0;
        else if (update_en) latch_q <= stage;
    end

    assert_update_load_R5: assert property (@(posedge clk) disable iff (rst)
        update_en |=> latch_q == $past(stage));

    assert_update_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !update_en |=> $stable(latch_q));

endmodule

// File: rtl/bsc_pad_select.sv
module bsc_pad_select
    import bsc_pkg::*;
(
    input  bsc_mode_t mode,
    input  bsc_pair_t latch,
    input  logic      core_oe,
    input  logic      core_do,
    input  logic      pad_di,
    output logic      pad_oe,
    output logic      pad_do,
    output logic      core_di
);

    always_comb begin
        if (mode.extest) begin
            pad_oe = latch.ctrl;
            pad_do = latch.data;
        end else begin
            pad_oe = core_oe;
            pad_do = core_do;
        end
        core_di = pad_di;
    end

endmodule

// File: rtl/bsc_pin_array.sv
module bsc_pin_array
    import bsc_pkg::*;
#(
    parameter int PINS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scan_in,
    input  logic            capture_en,
    input  logic            shift_en,
    input  logic            update_en,
    input  logic            mode_extest,
    input  logic            mode_sample,
    input  logic [PINS-1:0] core_oe,
    input  logic [PINS-1:0] core_do,
    input  logic [PINS-1:0] pad_di,
    output logic            scan_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_do,
    output logic [PINS-1:0] core_di,
    output logic            pullup_off
);

    localparam int LINKS = PINS + 1;

    bsc_act_e        act;
    bsc_mode_t       mode;
    logic [LINKS-1:0] link;

    always_comb begin
        act         = bsc_decode(capture_en, shift_en);
        mode.extest = mode_extest;
        mode.sample = mode_sample;
        pullup_off  = bsc_pull_off(mode);
    end

    assign link[0]  = scan_in;
    assign scan_out = link[PINS];

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        bsc_pair_t obs;
        bsc_pair_t stage;
        bsc_pair_t latch;

        always_comb begin
            obs.ctrl = core_oe[p];
            obs.data = pad_di[p];
        end

        bsc_scan_stages u_stages (
            .clk     (clk),
            .rst     (rst),
            .act     (act),
            .si      (link[p]),
            .observe (obs),
            .stage_q (stage)
        );

        assign link[p+1] = stage.data;

        bsc_update_hold u_hold (
            .clk       (clk),
            .rst       (rst),
            .update_en (update_en),
            .stage     (stage),
            .latch_q   (latch)
        );

        bsc_pad_select u_pad (
            .mode    (mode),
            .latch   (latch),
            .core_oe (core_oe[p]),
            .core_do (core_do[p]),
            .pad_di  (pad_di[p]),
            .pad_oe  (pad_oe[p]),
            .pad_do  (pad_do[p]),
            .core_di (core_di[p])
        );
    end

    // Under external test the pad must not move unless an update occurred.
    assert_pad_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        mode_extest && $past(mode_extest) && !$past(update_en)
        |-> $stable(pad_oe) && $stable(pad_do));

    // Outside external test the pad follows the core regardless of latches.
    assert_core_owns_pad_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_extest && $stable(core_oe) && $stable(core_do) && $past(update_en)
        |-> $stable(pad_oe) && $stable(pad_do));

endmodule

// File: tb/bsc_pin_array_test.sv
`timescale 1ns/1ps
module bsc_pin_array_test;

    localparam int PINS = 4;
    localparam int NB   = 2 * PINS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_in = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic mode_extest = 1'b0, mode_sample = 1'b0;
    logic [PINS-1:0] core_oe = '0, core_do = '0, pad_di = '0;
    logic scan_out, pullup_off;
    logic [PINS-1:0] pad_oe, pad_do, core_di;

    always #5 clk = ~clk;

    bsc_pin_array #(.PINS(PINS)) uut (
        .clk(clk), .rst(rst), .scan_in(scan_in), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .mode_extest(mode_extest),
        .mode_sample(mode_sample), .core_oe(core_oe), .core_do(core_do),
        .pad_di(pad_di), .scan_out(scan_out), .pad_oe(pad_oe), .pad_do(pad_do),
        .core_di(core_di), .pullup_off(pullup_off)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit chk_on = 1'b0;
    string phase = "R1";

    // Reference model: bit 2p = control stage of pin p, bit 2p+1 = data stage.
    logic [NB-1:0]   m_sr = '0;
    logic [PINS-1:0] m_uc = '0, m_ud = '0;

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (rst) begin
            m_sr = '0; m_uc = '0; m_ud = '0;
        end else begin
            if (update_en)
                for (int p = 0; p < PINS; p++) begin
                    m_uc[p] = m_sr[2*p];
                    m_ud[p] = m_sr[2*p+1];
                end
            if (capture_en)
                for (int p = 0; p < PINS; p++) begin
                    m_sr[2*p]   = core_oe[p];
                    m_sr[2*p+1] = pad_di[p];
                end
            else if (shift_en)
                m_sr = {m_sr[NB-2:0], scan_in};
        end
    end

    task automatic check(string tag, string what, logic [PINS-1:0] act, logic [PINS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s actual=%b expected=%b t=%0t", tag, phase, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(phase, "scan_out", {{(PINS-1){1'b0}}, scan_out}, {{(PINS-1){1'b0}}, m_sr[NB-1]});
            if (mode_extest) begin
                check("R6", "pad_oe", pad_oe, m_uc);
                check("R6", "pad_do", pad_do, m_ud);
            end else begin
                check("R7", "pad_oe", pad_oe, core_oe);
                check("R7", "pad_do", pad_do, core_do);
            end
            check("R8", "core_di", core_di, pad_di);
            check("R9", "pullup_off", {{(PINS-1){1'b0}}, pullup_off},
                  {{(PINS-1){1'b0}}, mode_extest | mode_sample});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic step(logic cap, logic shf, logic upd, logic si);
        @(posedge clk); #2;
        capture_en = cap; shift_en = shf; update_en = upd; scan_in = si;
    endtask

    task automatic wiggle();
        core_oe = PINS'($urandom); core_do = PINS'($urandom); pad_di = PINS'($urandom);
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        core_oe = '1; pad_di = '1; core_do = '1;
        repeat (3) @(posedge clk);
        #2 chk_on = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        check("R1", "scan_out after reset", {{(PINS-1){1'b0}}, scan_out}, '0);

        // R2: capture then shift out
        phase = "R2";
        core_oe = 4'b1010; pad_di = 4'b0110;
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        core_oe = 4'b0101; pad_di = 4'b1001;
        for (int i = 0; i < NB + 2; i++) step(0, 1, 0, i[0]);

        // R4: capture and shift together
        phase = "R4";
        core_oe = 4'b0011; pad_di = 4'b1100;
        step(1, 1, 0, 1);
        for (int i = 0; i < NB; i++) step(0, 1, 0, 1'b0);

        // R10: idle with moving inputs
        phase = "R10";
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1'b0);
        for (int i = 0; i < 6; i++) begin step(0, 0, 0, 1'b1); wiggle(); end
        for (int i = 0; i < NB; i++) step(0, 1, 0, 1'b0);

        // R7: preload under sample, core keeps the pads
        phase = "R7";
        mode_sample = 1'b1;
        for (int i = 0; i < NB; i++) step(0, 1, 0, 1'b1);
        step(0, 0, 1, 0);
        for (int i = 0; i < 8; i++) begin step(0, 0, 0, 0); wiggle(); end

        // R6 / R5: switch to external test, latched values reach the pads
        phase = "R5";
        mode_sample = 1'b0; mode_extest = 1'b1;
        for (int i = 0; i < 4; i++) begin step(0, 0, 0, 0); wiggle(); end
        for (int r = 0; r < 5; r++) begin
            for (int i = 0; i < NB; i++) begin step(0, 1, 0, 1'($urandom)); wiggle(); end
            step(0, 0, 1, 0);
            for (int i = 0; i < 3; i++) begin step(1, 0, 0, 0); wiggle(); end
        end

        // R9: mode combinations
        phase = "R9";
        for (int m = 0; m < 4; m++) begin
            mode_extest = m[0]; mode_sample = m[1];
            step(0, 0, 0, 0);
            step(0, 0, 0, 0);
        end

        // R3: random mix of strobes and modes
        phase = "R3";
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 5) == 0, ($urandom % 3) != 0, ($urandom % 6) == 0, 1'($urandom));
            if ((i % 37) == 0) begin mode_extest = 1'($urandom); mode_sample = 1'($urandom); end
            wiggle();
        end

        // R1: reset again from a busy state
        phase = "R1";
        step(0, 0, 0, 0);
        rst = 1'b1; mode_extest = 1'b1;
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "pad_oe latches cleared", pad_oe, '0);
        check("R1", "pad_do latches cleared", pad_do, '0);

        step(0, 0, 0, 0);
        @(negedge clk);
        chk_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule